// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit multiplies or divides two 32-bit integers, signed or unsigned, one result bit per clock. A single start pulse hands it an operation code and two operands. The unit then runs a fixed sequence of shift steps on one 64-bit working register and writes the outcome to two result registers, a high word and a low word. The two words are read through separate output ports. A multiply places the upper half of the 64-bit product in the high word and the lower half in the low word. A divide places the remainder in the high word and the quotient in the low word.

Signed operations take the magnitude of each operand and run the unsigned algorithm. A final cycle then corrects the sign. A processor pipeline uses the unit by pulsing start and watching busy. Done marks the cycle in which fresh results appear. The result registers keep their value until the next completion, so software can read them at any later time.

Top module: `mdu_iter`

## Requirements
- R1: After reset, busy and done are low and both result words read zero.
- R2: Operation code 1 (unsigned multiply) leaves bits 63..32 of the unsigned 64-bit product in the high word and bits 31..0 in the low word.
- R3: Operation code 0 (signed multiply) leaves the two's-complement 64-bit product of the signed operands split the same way.
- R4: Operation code 3 (unsigned divide) with a nonzero divisor leaves the quotient in the low word and the remainder in the high word.
- R5: Operation code 2 (signed divide) with a nonzero divisor rounds the quotient toward zero and gives the remainder the sign of the dividend. The most negative dividend divided by -1 yields quotient 0x80000000 and remainder 0.
- R6: A divide of either kind by zero completes normally, with the low word all ones and the high word equal to the dividend as given.
- R7: Busy rises in the cycle after the edge that accepts start. Thirty-three edges after that accepting edge, busy falls and done is high for exactly one cycle.
- R8: Start is accepted only while busy is low. A start pulse, or a change in operands or operation code, while busy is high has no effect on the running operation or its results.
- R9: The result words change only on the edge that raises done.
- R10: Busy and done are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Request a new operation |
| opIn | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| hiOut | output | 32 | High result word (product upper half or remainder) |
| loOut | output | 32 | Low result word (product lower half or quotient) |

## Verification
A wrong step count or a stuck control state appears at busy and done within 34 cycles of the accepting edge, because the reference model predicts both every cycle. Wrong state in the working register, such as a lost carry, a misplaced quotient bit or a bad restore, stays hidden until completion. At that edge it shows as a wrong high or low word, and the bench compares both words on every cycle. An operand captured late or recaptured shows up only in the operations where the bench changes the inputs, or pulses start, while the unit is busy.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } mdu_op_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;    // capture operands, initialise working register
    logic step;    // one shift/add or shift/subtract iteration
    logic finish;  // sign fix-up and write of the result words
  } mdu_strobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int unsigned STEPS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  output mdu_strobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e        state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.load   = (state == S_IDLE) && startIn;
    strobe.step   = (state == S_RUN);
    strobe.finish = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      unique case (state)
        S_IDLE: if (startIn) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: done never overlaps an operation in progress
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: a start seen mid-run does not restart or abort the run
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && startIn) |=> (state != S_IDLE) && (stepCnt != '0 || state == S_FIN));

  // R7: iterations end exactly at the configured count
  p_run_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && stepCnt == LAST) |=> strobe.finish);

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdu_strobe_t strobe,
  input  logic [1:0]  opIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);

  localparam int unsigned W2 = 2 * W;

  // working state
  logic [W2-1:0] acc;       // shared product / remainder:quotient register
  logic [W-1:0]  mcand;     // multiplicand or divisor magnitude
  logic [W-1:0]  dividendRaw;
  logic          isDiv, negHi, negLo, divZero;
  logic [W-1:0]  hiReg, loReg;

  // operand conditioning
  mdu_op_e       opSel;
  logic          isSigned, sgnA, sgnB;
  logic [W-1:0]  magA, magB;

  always_comb begin
    opSel    = mdu_op_e'(opIn);
    isSigned = (opSel == OP_MULS) || (opSel == OP_DIVS);
    sgnA     = isSigned & opA[W-1];
    sgnB     = isSigned & opB[W-1];
    magA     = sgnA ? (~opA + 1'b1) : opA;
    magB     = sgnB ? (~opB + 1'b1) : opB;
  end

  // one multiply iteration: conditional add on the left half, carry kept
  logic [W:0]    mulSum;
  logic [W2-1:0] mulNext;
  // one restoring-divide iteration on the left half
  logic [W:0]    divTop, divDiff;
  logic          divFits;
  logic [W2-1:0] divNext;

  always_comb begin
    mulSum  = {1'b0, acc[W2-1:W]} + {1'b0, mcand};
    mulNext = acc[0] ? {mulSum, acc[W-1:1]} : {1'b0, acc[W2-1:1]};

    divTop  = acc[W2-1:W-1];
    divDiff = divTop - {1'b0, mcand};
    divFits = (divTop >= {1'b0, mcand});
    divNext = divFits ? {divDiff[W-1:0], acc[W-2:0], 1'b1}
                      : {acc[W2-2:0], 1'b0};
  end

  // sign fix-up of the finished magnitudes
  logic [W2-1:0] prodFinal;
  logic [W-1:0]  quotFinal, remFinal;

  always_comb begin
    prodFinal = negHi ? (~acc + 1'b1) : acc;
    quotFinal = divZero ? '1
              : (negLo ? (~acc[W-1:0] + 1'b1) : acc[W-1:0]);
    remFinal  = divZero ? dividendRaw
              : (negHi ? (~acc[W2-1:W] + 1'b1) : acc[W2-1:W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      mcand       <= '0;
      dividendRaw <= '0;
      isDiv       <= 1'b0;
      negHi       <= 1'b0;
      negLo       <= 1'b0;
      divZero     <= 1'b0;
      hiReg       <= '0;
      loReg       <= '0;
    end else begin
      if (strobe.load) begin
        isDiv       <= (opSel == OP_DIVS) || (opSel == OP_DIVU);
        dividendRaw <= opA;
        divZero     <= (opB == '0);
        if ((opSel == OP_DIVS) || (opSel == OP_DIVU)) begin
          acc   <= {{W{1'b0}}, magA};
          mcand <= magB;
          negLo <= sgnA ^ sgnB;
          negHi <= sgnA;
        end else begin
          acc   <= {{W{1'b0}}, magB};
          mcand <= magA;
          negLo <= sgnA ^ sgnB;
          negHi <= sgnA ^ sgnB;
        end
      end else if (strobe.step) begin
        acc <= isDiv ? divNext : mulNext;
      end
      if (strobe.finish) begin
        if (isDiv) begin
          hiReg <= remFinal;
          loReg <= quotFinal;
        end else begin
          hiReg <= prodFinal[W2-1:W];
          loReg <= prodFinal[W-1:0];
        end
      end
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

  // R9: result words move only when control signals completion
  p_hilo_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(hiReg) && $stable(loReg));

  // R4: partial remainder stays below the divisor after every step
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && isDiv && mcand != '0) |=> (acc[W2-1:W] < mcand));

  // R8: captured operand is held for the whole run
  p_mcand_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(mcand));

  // R2: a fresh load starts with an empty left half
  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (acc[W2-1:W] == '0));

endmodule

// File: rtl/mdu_iter.sv
module mdu_iter
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [1:0]   opIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busyOut,
  output logic         doneOut,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);

  mdu_strobe_t strobe;

  mdu_ctrl #(.STEPS(W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobe  (strobe),
    .busy    (busyOut),
    .done    (doneOut)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opIn   (opIn),
    .opA    (opA),
    .opB    (opB),
    .hiOut  (hiOut),
    .loOut  (loOut)
  );

endmodule

// File: tb/test_mdu_iter.sv
module test_mdu_iter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  opIn = 2'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        busyOut, doneOut;
  logic [31:0] hiOut, loOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  mdu_iter i_mdu_iter (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opIn(opIn),
    .opA(opA), .opB(opB), .busyOut(busyOut), .doneOut(doneOut),
    .hiOut(hiOut), .loOut(loOut)
  );

  // ---------------- behavioural reference ----------------
  logic        mBusy = 1'b0, mDone = 1'b0;
  logic [31:0] mHi = '0, mLo = '0, eHi = '0, eLo = '0;
  int          mCnt = 0;
  string       curTag = "R1";
  string       pendTag = "R1";

  task automatic calc(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      output logic [31:0] h, output logic [31:0] l, output string t);
    logic signed [63:0] sa, sb, p, q, r;
    logic [63:0] up;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (op)
      2'd0: begin p = sa * sb; h = p[63:32]; l = p[31:0]; t = "R3"; end
      2'd1: begin up = {32'b0, a} * {32'b0, b}; h = up[63:32]; l = up[31:0]; t = "R2"; end
      2'd2: begin
        if (b == 0) begin h = a; l = '1; t = "R6"; end
        else begin q = sa / sb; r = sa % sb; h = r[31:0]; l = q[31:0]; t = "R5"; end
      end
      default: begin
        if (b == 0) begin h = a; l = '1; t = "R6"; end
        else begin h = a % b; l = a / b; t = "R4"; end
      end
    endcase
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mHi = '0; mLo = '0;
    end else begin
      logic accept;
      accept = !mBusy && startIn;
      mDone = 0;
      if (mCnt > 0) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) begin
          mBusy = 0; mDone = 1; mHi = eHi; mLo = eLo; curTag = pendTag;
        end
      end
      if (accept) begin
        mBusy = 1; mCnt = 33;
        calc(opIn, opA, opB, eHi, eLo, pendTag);
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R7", "busy", {31'b0, busyOut}, {31'b0, mBusy});
      chk("R7", "done", {31'b0, doneOut}, {31'b0, mDone});
      chk(mBusy ? "R9" : curTag, "hi", hiOut, mHi);
      chk(mBusy ? "R9" : curTag, "lo", loOut, mLo);
      chk("R10", "busy&done", {31'b0, busyOut & doneOut}, 32'd0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      testsFailed++;
      $display("FAIL R7 watchdog expired, actual still running expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // run one operation; optionally disturb inputs and pulse start mid-run (R8)
  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input bit poke);
    logic [31:0] h, l;
    string t;
    calc(op, a, b, h, l, t);
    @(negedge clk);
    startIn = 1; opIn = op; opA = a; opB = b;
    @(negedge clk);
    startIn = 0; opA = ~a; opB = b + 32'd7; opIn = ~op;
    for (int i = 0; i < 33; i++) begin
      @(negedge clk);
      if (poke && (i == 5 || i == 31)) begin
        startIn = 1; opA = $urandom; opB = $urandom; opIn = 2'($urandom);
      end else begin
        startIn = 0;
      end
    end
    // done pulse cycle has been sampled; results stable now
    if (poke) begin
      chk("R8", "hi after mid-run start", hiOut, h);
      chk("R8", "lo after mid-run start", loOut, l);
    end
    startIn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busyOut}, 32'd0);
    chk("R1", "done", {31'b0, doneOut}, 32'd0);
    chk("R1", "hi", hiOut, 32'd0);
    chk("R1", "lo", loOut, 32'd0);
    rstN = 1;
    @(negedge clk);

    // R2 unsigned multiply corners
    runOp(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    runOp(2'd1, 32'd13, 32'd11, 0);
    runOp(2'd1, 32'h8000_0000, 32'd2, 0);
    // R3 signed multiply corners
    runOp(2'd0, 32'hFFFF_FFFF, 32'd5, 0);
    runOp(2'd0, 32'h8000_0000, 32'h8000_0000, 0);
    runOp(2'd0, 32'hFFFF_FFF9, 32'hFFFF_FFFD, 0);
    // R4 unsigned divide
    runOp(2'd3, 32'd100, 32'd7, 0);
    runOp(2'd3, 32'hFFFF_FFFF, 32'd1, 0);
    runOp(2'd3, 32'd3, 32'hFFFF_FFFF, 0);
    // R5 signed divide, sign of remainder follows dividend
    runOp(2'd2, 32'hFFFF_FF9C, 32'd7, 0);
    runOp(2'd2, 32'd100, 32'hFFFF_FFF9, 0);
    runOp(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    // R6 divide by zero
    runOp(2'd3, 32'h1234_5678, 32'd0, 0);
    runOp(2'd2, 32'hFEDC_BA98, 32'd0, 0);
    // R8 mid-run start pulses ignored
    runOp(2'd0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1);
    runOp(2'd2, 32'h8765_4321, 32'd12345, 1);

    // R7 start held high: back-to-back acceptance after each completion
    @(negedge clk);
    startIn = 1; opIn = 2'd1; opA = 32'd77; opB = 32'd99;
    repeat (80) @(negedge clk);
    startIn = 0;
    repeat (40) @(negedge clk);

    // random mix of all operations
    for (int k = 0; k < 40; k++) begin
      logic [31:0] rb;
      rb = ((k % 9) == 0) ? 32'd0 : 32'($urandom);
      runOp(2'($urandom), 32'($urandom), rb, (k % 5) == 0);
    end

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule